// File: doc/BRIEF.md
# Double-Length Accumulator/Extension Shifter

This block holds a 12-bit accumulator (A) and a 12-bit extension register (Q) and shifts them as one double-length operand. The top bit of each register is a sign bit. It is held out of the shifted path, so only the 11 data bits of A and the 11 data bits of Q form a 22-bit chain. The chain is shifted one place per clock, for as many places as the requested count.

Operands are loaded through a parallel load port while the block is idle. A start strobe then launches either a multi-cycle shift, left or right, or a single-cycle whole-register copy from A to Q or from Q to A. The block raises `busy` for the length of a shift and pulses `done` in the cycle the result is final. Shifting the chain by one register's data width moves the data of one register into the other and leaves the source's data empty.

Top module: `aqs_shifter`

## Requirements
- R1: During and after a synchronous active-low reset, A and Q read zero and `busy` and `done` are low.
- R2: With `busy` low and `start` low, `load` writes `a_in` to A and `q_in` to Q at the next edge. `load` is ignored while `busy` is high, and it is ignored when `start` is high in the same cycle. With no `start` and no `load` while idle, A and Q hold their values.
- R3: A shift never changes bit 11 of A or bit 11 of Q.
- R4: A right shift (`op` = 2'b01) moves each data bit one place toward bit 0 of Q. A bit 0 enters Q bit 10, a zero enters A bit 10, and Q bit 0 is lost.
- R5: A left shift (`op` = 2'b00) moves each data bit one place toward bit 10 of A. Q bit 10 enters A bit 0, a zero enters Q bit 0, and A bit 10 is lost.
- R6: For a shift count N from 1 to 22, `busy` rises at the start edge and stays high for N cycles. The shift is applied at each of the N following edges. At the Nth edge `busy` falls, `done` is high for that cycle, and the result is final.
- R7: A shift with a count of 0 raises `done` at the start edge, leaves A and Q unchanged, and never raises `busy`.
- R8: A count above 22 behaves exactly like a count of 22, which clears every data bit.
- R9: A right shift of 11 places moves A's data bits into Q's data bits and clears A's data bits. A left shift of 11 places does the reverse.
- R10: `op` = 2'b10 copies all 12 bits of A into Q, and `op` = 2'b11 copies all 12 bits of Q into A. Each copy completes at the start edge with a `done` pulse, leaves the source unchanged, and does not raise `busy`.
- R11: A `start` while `busy` is high is ignored; the running shift finishes with the result of the original request.
- R12: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Parallel load of A and Q while idle |
| a_in | input | 12 | Load value for A |
| q_in | input | 12 | Load value for Q |
| start | input | 1 | Launch the operation selected by `op` |
| op | input | 2 | 00 shift left, 01 shift right, 10 copy A to Q, 11 copy Q to A |
| count | input | 5 | Shift places, saturated at 22 |
| a_out | output | 12 | Accumulator contents |
| q_out | output | 12 | Extension register contents |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on a single-cycle `start` strobe: the copy and zero-count properties compare the register contents one edge after a `start` seen while idle. The bench drives `start` and `load` for exactly one cycle each, away from the clock edge, and only changes `op` and `count` together with `start`. The per-step shift properties take the latched operation as the only source of direction. The stimulus therefore includes a `start` with a different operation while busy, along with a `load`, to confirm that neither disturbs the latched request.

// File: rtl/aqs_pkg.sv
// Package: shared operation codes for the double-length shifter.
// Assumes a two-bit operation field on the block's port.
package aqs_pkg;
    typedef enum logic [1:0] {
        OP_SHL   = 2'b00,
        OP_SHR   = 2'b01,
        OP_CP_AQ = 2'b10,
        OP_CP_QA = 2'b11
    } aq_op_e;

    // True when the operation walks the chain rather than copying.
    function automatic logic is_shift(input aq_op_e o);
        return (o == OP_SHL) || (o == OP_SHR);
    endfunction
endpackage

// File: rtl/aqs_chain.sv
// Module: one-place shift of the concatenated data bits of A and Q.
// Sign bits are not part of this module's view. A zero enters at the open
// end of the chain and the bit leaving the far end is dropped.
// Assumes DW >= 2.
module aqs_chain #(
    parameter int DW = 11
) (
    input  logic [DW-1:0] a_dat,
    input  logic [DW-1:0] q_dat,
    input  logic          go_left,
    output logic [DW-1:0] a_nxt,
    output logic [DW-1:0] q_nxt
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] chain;
    logic [CW-1:0] shifted;

    // Join A above Q into a single chain.
    always_comb chain = {a_dat, q_dat};

    // Each chain position selects its left or right neighbour.
    generate
        for (genvar i = 0; i < CW; i++) begin : g_bit
            if (i == 0) begin : g_low
                assign shifted[i] = go_left ? 1'b0 : chain[i+1];
            end else if (i == CW - 1) begin : g_high
                assign shifted[i] = go_left ? chain[i-1] : 1'b0;
            end else begin : g_mid
                assign shifted[i] = go_left ? chain[i-1] : chain[i+1];
            end
        end
    endgenerate

    // Split the chain back into the two register data fields.
    always_comb begin
        a_nxt = shifted[CW-1:DW];
        q_nxt = shifted[DW-1:0];
    end
endmodule

// File: rtl/aqs_seq.sv
// Module: operation sequencer for the double-length shifter.
// Accepts a start only while idle, latches the operation, saturates the
// count, and steps the chain once per cycle until the count runs out.
// Copies and zero counts finish at the start edge without raising busy.
module aqs_seq #(
    parameter int DW = 11,
    localparam int MAXSH = 2 * DW,
    localparam int CNTW = $clog2(MAXSH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load,
    input  aqs_pkg::aq_op_e  op,
    input  logic [CNTW-1:0]  count,
    output aqs_pkg::aq_op_e  op_q,
    output logic             step,
    output logic             cp_aq,
    output logic             cp_qa,
    output logic             load_ok,
    output logic             busy,
    output logic             done
);
    import aqs_pkg::*;

    logic [CNTW-1:0] eff_cnt;
    logic [CNTW-1:0] remain;
    logic            take;

    // Clamp the requested count to the chain length.
    always_comb eff_cnt = (count > CNTW'(MAXSH)) ? CNTW'(MAXSH) : count;

    // Decode the single-edge actions from the idle state.
    always_comb begin
        take    = start && !busy;
        cp_aq   = take && (op == OP_CP_AQ);
        cp_qa   = take && (op == OP_CP_QA);
        load_ok = load && !busy && !start;
        step    = busy;
    end

    // Track the latched operation, the remaining places and the handshake flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
            op_q   <= OP_SHL;
        end else begin
            done <= 1'b0;
            if (take) begin
                op_q <= op;
                if (!is_shift(op) || (eff_cnt == '0)) begin
                    done <= 1'b1;
                end else begin
                    busy   <= 1'b1;
                    remain <= eff_cnt;
                end
            end else if (busy) begin
                remain <= remain - 1'b1;
                if (remain == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aqs_shifter.sv
// Module: top of the double-length A/Q shifter.
// Holds A and Q and applies load, copy and per-place shift updates chosen by
// the sequencer. Bit W-1 of each register is a sign bit that shifts never
// write. Assumes start and load are single-cycle strobes from the host.
module aqs_shifter #(
    parameter int W = 12,
    localparam int DW = W - 1,
    localparam int MAXSH = 2 * DW,
    localparam int CNTW = $clog2(MAXSH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    q_in,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [CNTW-1:0] count,
    output logic [W-1:0]    a_out,
    output logic [W-1:0]    q_out,
    output logic            busy,
    output logic            done
);
    import aqs_pkg::*;

    logic [W-1:0]  a_r;
    logic [W-1:0]  q_r;
    logic [DW-1:0] a_step;
    logic [DW-1:0] q_step;
    aq_op_e        op_q;
    aq_op_e        op_in;
    logic          step;
    logic          cp_aq;
    logic          cp_qa;
    logic          load_ok;

    // Map the raw port code onto the operation type.
    always_comb op_in = aq_op_e'(op);

    aqs_seq #(.DW(DW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .op      (op_in),
        .count   (count),
        .op_q    (op_q),
        .step    (step),
        .cp_aq   (cp_aq),
        .cp_qa   (cp_qa),
        .load_ok (load_ok),
        .busy    (busy),
        .done    (done)
    );

    aqs_chain #(.DW(DW)) u_chain (
        .a_dat   (a_r[DW-1:0]),
        .q_dat   (q_r[DW-1:0]),
        .go_left (op_q == OP_SHL),
        .a_nxt   (a_step),
        .q_nxt   (q_step)
    );

    // Update the register pair from load, copy or one shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r <= '0;
            q_r <= '0;
        end else if (load_ok) begin
            a_r <= a_in;
            q_r <= q_in;
        end else if (cp_aq) begin
            q_r <= a_r;
        end else if (cp_qa) begin
            a_r <= q_r;
        end else if (step) begin
            a_r[DW-1:0] <= a_step;
            q_r[DW-1:0] <= q_step;
        end
    end

    // Drive the register contents onto the outputs.
    always_comb begin
        a_out = a_r;
        q_out = q_r;
    end
endmodule

// File: rtl/aqs_shifter_chk.sv
// Checker: temporal properties of the double-length shifter, bound to the top.
// Assumes start is a single-cycle strobe sampled at the clock edge.
module aqs_shifter_chk #(
    parameter int W = 12,
    localparam int DW = W - 1,
    localparam int CNTW = $clog2(2 * DW + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            load,
    input logic            start,
    input logic [1:0]      op,
    input logic [CNTW-1:0] count,
    input logic [W-1:0]    a_out,
    input logic [W-1:0]    q_out,
    input logic            busy,
    input logic            done,
    input logic [1:0]      op_q
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !load) |=> ($stable(a_out) && $stable(q_out))); // R2
    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_out[W-1]) && $stable(q_out[W-1]))); // R3
    AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == 2'b01) |=> (a_out[DW-1] == 1'b0 && q_out[DW-1] == $past(a_out[0]))); // R4
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == 2'b00) |=> (q_out[0] == 1'b0 && a_out[0] == $past(q_out[DW-1]))); // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op[1] && count == '0) |=> (done && !busy && $stable(a_out) && $stable(q_out))); // R7
    AST_COPY_AQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 2'b10) |=> (q_out == $past(a_out) && $stable(a_out) && done)); // R10
    AST_COPY_QA: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 2'b11) |=> (a_out == $past(q_out) && $stable(q_out) && done)); // R10
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R12
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) || $past(start))); // R6
endmodule

bind aqs_shifter aqs_shifter_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .start (start),
    .op    (op),
    .count (count),
    .a_out (a_out),
    .q_out (q_out),
    .busy  (busy),
    .done  (done),
    .op_q  (op_q)
);

// File: tb/sim_aqs_shifter.sv
module sim_aqs_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [11:0] a_in = '0;
    logic [11:0] q_in = '0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [4:0]  count = '0;
    logic [11:0] a_out;
    logic [11:0] q_out;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    aqs_shifter u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .q_in(q_in),
        .start(start), .op(op), .count(count), .a_out(a_out), .q_out(q_out),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected {A, Q} after an operation, from the requirements.
    function automatic logic [23:0] model(input logic [11:0] a, input logic [11:0] q,
                                          input logic [1:0] o, input int cnt);
        logic [21:0] ch;
        int n;
        if (o == 2'b10) return {a, a};
        if (o == 2'b11) return {q, q};
        n = (cnt > 22) ? 22 : cnt;
        ch = {a[10:0], q[10:0]};
        ch = (o == 2'b00) ? (ch << n) : (ch >> n);
        return {a[11], ch[21:11], q[11], ch[10:0]};
    endfunction

    task automatic do_load(input logic [11:0] a, input logic [11:0] q);
        @(negedge clk);
        load = 1'b1; a_in = a; q_in = q;
        @(negedge clk);
        load = 1'b0;
        check({a_out, q_out} == {a, q}, "R2", "load", {8'h0, a_out, q_out}, {8'h0, a, q});
    endtask

    // Run one operation; optionally poke start and load while busy (R11).
    task automatic run_op(input logic [1:0] o, input int cnt, input bit poke, input string req);
        logic [23:0] exp;
        int n;
        exp = model(a_out, q_out, o, cnt);
        n = (cnt > 22) ? 22 : cnt;
        @(negedge clk);
        start = 1'b1; op = o; count = 5'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (o[1] || n == 0) begin
            check(done && !busy, req, "single-edge done/busy", {30'h0, done, busy}, 32'h2);
        end else begin
            check(busy && !done, "R6", "busy after start", {30'h0, done, busy}, 32'h1);
            if (poke && n >= 2) begin
                start = 1'b1; op = ~o; count = 5'd0;
                load = 1'b1; a_in = 12'hABC; q_in = 12'h123;
                @(negedge clk);
                start = 1'b0; load = 1'b0;
                check(busy, "R11", "busy kept after ignored start", {31'h0, busy}, 32'h1);
                repeat (n - 1) @(posedge clk);
            end else begin
                repeat (n) @(posedge clk);
            end
            @(negedge clk);
            check(done && !busy, "R6", "done at final edge", {30'h0, done, busy}, 32'h2);
        end
        check({a_out, q_out} == exp, req, "result", {8'h0, a_out, q_out}, {8'h0, exp});
        @(negedge clk);
        check(!done, "R12", "done is one cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C));
        repeat (3) @(negedge clk);
        check({a_out, q_out, busy, done} == '0, "R1", "reset state",
              {6'h0, a_out, q_out, busy, done}, 32'h0);
        rst_n = 1'b1;
        // R4 single step right: A bit0 into Q bit10, sign bits held (R3)
        do_load(12'hFFF, 12'h000);
        run_op(2'b01, 1, 1'b0, "R4");
        check(a_out[11] && !q_out[11] && q_out[10], "R3", "signs after right", {20'h0, a_out[11], q_out[11:0]}, 32'h1400);
        // R5 single step left: Q bit10 into A bit0
        do_load(12'h000, 12'h400);
        run_op(2'b00, 1, 1'b0, "R5");
        // R9 full data width transfers
        do_load(12'h5A5, 12'h800);
        run_op(2'b01, 11, 1'b1, "R9");
        check(a_out[10:0] == 11'h0, "R9", "A data empty", {21'h0, a_out[10:0]}, 32'h0);
        do_load(12'h000, 12'h3C3);
        run_op(2'b00, 11, 1'b0, "R9");
        // R7 zero count, R8 saturation
        do_load(12'h7FF, 12'hFFF);
        run_op(2'b00, 0, 1'b0, "R7");
        run_op(2'b01, 31, 1'b0, "R8");
        check(a_out == 12'h000 && q_out == 12'h800, "R8", "saturated clear", {8'h0, a_out, q_out}, 32'h000800);
        // R10 copies
        do_load(12'h9AB, 12'h456);
        run_op(2'b10, 5, 1'b0, "R10");
        do_load(12'h9AB, 12'h456);
        run_op(2'b11, 0, 1'b0, "R10");
        // R2 load ignored together with start
        do_load(12'h111, 12'h222);
        @(negedge clk);
        start = 1'b1; op = 2'b00; count = 5'd0; load = 1'b1; a_in = 12'hEEE; q_in = 12'hDDD;
        @(negedge clk);
        start = 1'b0; load = 1'b0;
        check({a_out, q_out} == 24'h111222, "R2", "load with start ignored", {8'h0, a_out, q_out}, 32'h111222);
        // Constrained random mix, with pokes while busy (R11)
        for (int k = 0; k < 150; k++) begin
            logic [1:0] o;
            int c;
            do_load(12'($urandom), 12'($urandom));
            o = 2'($urandom_range(0, 3));
            c = ($urandom_range(0, 9) == 0) ? int'($urandom_range(23, 31)) : int'($urandom_range(0, 22));
            run_op(o, c, 1'($urandom), (o[1]) ? "R10" : (o[0] ? "R4" : "R5"));
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule